// File: doc/BRIEF.md
# Serial EEPROM Dword Write Sequencer

This block performs one 32-bit write to a serial configuration EEPROM that sits behind a small register set. The registers are a control register, a protection-boundary register, a data register and an address/flag register. A caller presents a byte offset and a data word with a one-cycle `start`. The sequencer rejects offsets that are not dword aligned. For an aligned offset it clears the EEPROM input-enable control bit and lowers the protection boundary to the target dword. It then stores the word, launches the transfer by writing the address with its flag bit set, and polls the flag after a fixed delay until the write is complete. The polling has a bound.

When the write phase is over, the block puts back the saved protection and control values. It then reads the word back through the same address/flag mechanism and compares it with the written data. One `done` pulse carries a 2-bit status: 00 success, 01 misaligned offset, 10 timeout, 11 readback mismatch.

All register traffic goes through one request/acknowledge port. The port holds a request until the responder acknowledges it. Read data is taken in the acknowledge cycle.

Top module: `eeprom_wr_seq`

## Requirements
- R1: When `start` is accepted with `offset[1:0]` not 00, `done` rises in the next cycle with status 01, and no register request is made for that command.
- R2: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` while `busy` is ignored: no second `done` follows, and no access is made for that offset.
- R3: The first two accesses read the control register (select 00) and then write it back with bit 31 cleared. The last control write of the command restores the value that was read.
- R4: Next, the protection register (select 01) is read and then written with `offset[8:2]`, zero-extended. After polling ends, the saved value is written back before the control register is restored.
- R5: The data register (select 10) is written with the data word. Only after that is the address register (select 11) written with the offset OR 0x8000.
- R6: Each poll of the address register comes at least DELAY idle cycles after the previous access. A read with bit 15 clear marks the write complete. Completion on the POLLS-th read still counts as success.
- R7: If all POLLS write-phase reads return bit 15 set, the status is 10. Restoration and readback still run.
- R8: Readback writes the address register with the offset and bit 15 clear. It then polls, with the same delay and bound, until bit 15 reads set (data ready), and then reads the data register. If no read shows ready, the status is 10.
- R9: The status is 11 when the readback word differs from the written word and no timeout occurred, and 00 when the two match. A timeout takes precedence over a mismatch.
- R10: `done` is high for exactly one cycle. While `reg_req` waits for `reg_ack`, the select, write-enable and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken when not busy |
| offset | input | AW | Byte offset of the target dword |
| wdata | input | DW | Word to write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code, valid with `done` |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_sel | output | 2 | 00 control, 01 protection, 10 data, 11 address/flag |
| reg_wdata | output | DW | Register write data |
| reg_ack | input | 1 | Access acknowledge, one cycle |
| reg_rdata | input | DW | Read data, valid with `reg_ack` |

## Verification
A misaligned command shows `done` one cycle after its `start` edge. The bench checks that pulse at the first falling edge after that edge, and `done` must be low again at the next falling edge. The bench's register model acknowledges on the falling edge after a request. Each access therefore spans two cycles, and consecutive polls are DELAY+1 cycles apart. The model stamps every served access with the cycle count, and the bench compares these gaps with that lower bound. For a full command the bench waits on `done` instead of predicting its cycle, because the total length depends on the poll counts. It then checks the order and values of the whole access trace, which it rebuilds from the offset, the data and the poll counts it configured in the model.

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq #(
  parameter int DW          = 32,
  parameter int AW          = 16,
  parameter int DELAY       = 8,
  parameter int POLLS       = 10,
  parameter int PROT_W      = 7,
  parameter int CTRL_EN_BIT = 31,
  parameter int FLAG_BIT    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] offset,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic          reg_req,
  output logic          reg_we,
  output logic [1:0]    reg_sel,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack,
  input  logic [DW-1:0] reg_rdata
);

  localparam int DCW = $clog2(DELAY + 1);
  localparam int PCW = $clog2(POLLS + 1);
  localparam logic [DW-1:0] FLAG_M = DW'(1) << FLAG_BIT;
  localparam logic [DW-1:0] CEN_M  = DW'(1) << CTRL_EN_BIT;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PROT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_ADDR = 2'd3;

  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_ALGN = 2'd1;
  localparam logic [1:0] ST_TOUT = 2'd2;
  localparam logic [1:0] ST_MISM = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_GET_CTRL, S_PUT_CTRL, S_GET_PROT, S_PUT_PROT, S_SETTLE,
    S_PUT_DATA, S_LAUNCH, S_WAIT, S_POLL, S_REST_PROT, S_REST_CTRL,
    S_RB_LAUNCH, S_RB_WAIT, S_RB_POLL, S_RB_DATA, S_DONE
  } state_t;

  state_t          st;
  logic [AW-1:0]   ofs_q;
  logic [DW-1:0]   dat_q;
  logic [DW-1:0]   ctrl_sv;
  logic [DW-1:0]   prot_sv;
  logic [DCW-1:0]  dcnt;
  logic [PCW-1:0]  pcnt;
  logic [1:0]      stat_q;

  logic [DW-1:0] ofs_w;
  logic [DW-1:0] prot_new;
  logic          dly_end;
  logic          poll_last;
  logic          flag_rd;

  assign ofs_w     = DW'(ofs_q);
  assign prot_new  = DW'(ofs_q[PROT_W+1:2]);
  assign dly_end   = (dcnt == DCW'(DELAY - 1));
  assign poll_last = (pcnt == PCW'(POLLS - 1));
  assign flag_rd   = reg_rdata[FLAG_BIT];

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_DONE);
  assign status = stat_q;

  always_comb begin
    reg_req   = 1'b1;
    reg_we    = 1'b0;
    reg_sel   = SEL_CTRL;
    reg_wdata = '0;
    case (st)
      S_GET_CTRL:  begin reg_sel = SEL_CTRL; end
      S_PUT_CTRL:  begin reg_sel = SEL_CTRL; reg_we = 1'b1; reg_wdata = ctrl_sv & ~CEN_M; end
      S_GET_PROT:  begin reg_sel = SEL_PROT; end
      S_PUT_PROT:  begin reg_sel = SEL_PROT; reg_we = 1'b1; reg_wdata = prot_new; end
      S_PUT_DATA:  begin reg_sel = SEL_DATA; reg_we = 1'b1; reg_wdata = dat_q; end
      S_LAUNCH:    begin reg_sel = SEL_ADDR; reg_we = 1'b1; reg_wdata = ofs_w | FLAG_M; end
      S_POLL:      begin reg_sel = SEL_ADDR; end
      S_REST_PROT: begin reg_sel = SEL_PROT; reg_we = 1'b1; reg_wdata = prot_sv; end
      S_REST_CTRL: begin reg_sel = SEL_CTRL; reg_we = 1'b1; reg_wdata = ctrl_sv; end
      S_RB_LAUNCH: begin reg_sel = SEL_ADDR; reg_we = 1'b1; reg_wdata = ofs_w & ~FLAG_M; end
      S_RB_POLL:   begin reg_sel = SEL_ADDR; end
      S_RB_DATA:   begin reg_sel = SEL_DATA; end
      default:     begin reg_req = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ofs_q   <= '0;
      dat_q   <= '0;
      ctrl_sv <= '0;
      prot_sv <= '0;
      dcnt    <= '0;
      pcnt    <= '0;
      stat_q  <= ST_OK;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (offset[1:0] != 2'b00) begin
            stat_q <= ST_ALGN;
            st     <= S_DONE;
          end else begin
            ofs_q  <= offset;
            dat_q  <= wdata;
            stat_q <= ST_OK;
            pcnt   <= '0;
            st     <= S_GET_CTRL;
          end
        end
        S_GET_CTRL: if (reg_ack) begin
          ctrl_sv <= reg_rdata;
          st      <= S_PUT_CTRL;
        end
        S_PUT_CTRL: if (reg_ack) st <= S_GET_PROT;
        S_GET_PROT: if (reg_ack) begin
          prot_sv <= reg_rdata;
          st      <= S_PUT_PROT;
        end
        S_PUT_PROT: if (reg_ack) begin
          dcnt <= '0;
          st   <= S_SETTLE;
        end
        S_SETTLE: begin
          if (dly_end) st <= S_PUT_DATA;
          else dcnt <= dcnt + 1'b1;
        end
        S_PUT_DATA: if (reg_ack) st <= S_LAUNCH;
        S_LAUNCH: if (reg_ack) begin
          dcnt <= '0;
          pcnt <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (dly_end) st <= S_POLL;
          else dcnt <= dcnt + 1'b1;
        end
        S_POLL: if (reg_ack) begin
          if (!flag_rd) begin
            st <= S_REST_PROT;
          end else if (poll_last) begin
            stat_q <= ST_TOUT;
            st     <= S_REST_PROT;
          end else begin
            pcnt <= pcnt + 1'b1;
            dcnt <= '0;
            st   <= S_WAIT;
          end
        end
        S_REST_PROT: if (reg_ack) st <= S_REST_CTRL;
        S_REST_CTRL: if (reg_ack) st <= S_RB_LAUNCH;
        S_RB_LAUNCH: if (reg_ack) begin
          dcnt <= '0;
          pcnt <= '0;
          st   <= S_RB_WAIT;
        end
        S_RB_WAIT: begin
          if (dly_end) st <= S_RB_POLL;
          else dcnt <= dcnt + 1'b1;
        end
        S_RB_POLL: if (reg_ack) begin
          if (flag_rd) begin
            st <= S_RB_DATA;
          end else if (poll_last) begin
            stat_q <= ST_TOUT;
            st     <= S_RB_DATA;
          end else begin
            pcnt <= pcnt + 1'b1;
            dcnt <= '0;
            st   <= S_RB_WAIT;
          end
        end
        S_RB_DATA: if (reg_ack) begin
          if (stat_q == ST_OK && reg_rdata != dat_q) stat_q <= ST_MISM;
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_wr_seq_chk.sv
module eeprom_wr_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] offset,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status,
  input logic          reg_req,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] reg_wdata,
  input logic          reg_ack
);

  p_misalign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && offset[1:0] != 2'b00 |=> done && status == 2'b01 && !reg_req);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req);

  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_sel) && $stable(reg_we) && $stable(reg_wdata));

endmodule

bind eeprom_wr_seq eeprom_wr_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .busy(busy),
  .done(done), .status(status), .reg_req(reg_req), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_ack(reg_ack)
);

// File: tb/eeprom_wr_seq_tb.sv
module eeprom_wr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY   = 3;
  localparam int NPOLL = 10;
  localparam int HANG  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] offset = '0;
  logic [31:0] wdata = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic        reg_req, reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        reg_ack = 1'b0;
  logic [31:0] reg_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wr_seq #(.DELAY(DLY), .POLLS(NPOLL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .wdata(wdata),
    .busy(busy), .done(done), .status(status), .reg_req(reg_req), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [31:0] m_ctrl, m_prot, m_data, m_addr;
  logic [31:0] mem [0:127];
  int wlat = 0, rlat = 0, wr_pend = 0, rd_pend = 0;
  bit corrupt = 0;
  logic [1:0]  lg_sel [0:63];
  logic        lg_we  [0:63];
  logic [31:0] lg_wd  [0:63];
  int          lg_cyc [0:63];
  int          lg_n = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (reg_ack) reg_ack = 1'b0;
    else if (reg_req) begin
      if (lg_n < 64) begin
        lg_sel[lg_n] = reg_sel; lg_we[lg_n] = reg_we;
        lg_wd[lg_n] = reg_wdata; lg_cyc[lg_n] = cyc; lg_n++;
      end
      reg_ack = 1'b1;
      reg_rdata = '0;
      case (reg_sel)
        2'd0: if (reg_we) m_ctrl = reg_wdata; else reg_rdata = m_ctrl;
        2'd1: if (reg_we) m_prot = reg_wdata; else reg_rdata = m_prot;
        2'd2: if (reg_we) m_data = reg_wdata; else reg_rdata = m_data;
        default: begin
          if (reg_we) begin
            m_addr = reg_wdata;
            if (reg_wdata[15]) begin
              wr_pend = wlat;
              if (!m_ctrl[31] && reg_wdata[8:2] >= m_prot[6:0])
                mem[reg_wdata[8:2]] = corrupt ? (m_data ^ 32'h1) : m_data;
            end else rd_pend = rlat;
          end else if (m_addr[15]) begin
            if (wr_pend > 0) begin reg_rdata = m_addr; wr_pend--; end
            else reg_rdata = m_addr & ~32'h8000;
          end else begin
            if (rd_pend > 0) begin reg_rdata = m_addr; rd_pend--; end
            else begin m_data = mem[m_addr[8:2]]; reg_rdata = m_addr | 32'h8000; end
          end
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] c, input logic [31:0] p, input int wl, input int rl, input bit cor);
    m_ctrl = c; m_prot = p; m_data = '0; m_addr = '0;
    wlat = wl; rlat = rl; corrupt = cor; wr_pend = 0; rd_pend = 0;
  endtask

  task automatic run_op(input logic [15:0] o, input logic [31:0] d, input int poke,
                        output logic [1:0] st, output int lat);
    @(negedge clk);
    lg_n = 0; start = 1'b1; offset = o; wdata = d;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 20000) begin
      if (lat == poke) begin start = 1'b1; offset = 16'h0040; wdata = 32'hDEAD0040; end
      else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    st = status;
    @(negedge clk);
    chk(!done, "R10 done pulse width", 32'(done), 32'h0);
  endtask

  task automatic check_trace(input string req, input logic [15:0] o, input logic [31:0] d,
                             input logic [31:0] c0, input logic [31:0] p0, input int nw, input int nr);
    logic [1:0]  es [0:63];
    logic        ew [0:63];
    logic [31:0] ed [0:63];
    int n = 0;
    int bad = -1;
    es[n] = 0; ew[n] = 0; ed[n] = 0; n++;
    es[n] = 0; ew[n] = 1; ed[n] = c0 & 32'h7FFF_FFFF; n++;
    es[n] = 1; ew[n] = 0; ed[n] = 0; n++;
    es[n] = 1; ew[n] = 1; ed[n] = 32'(o[8:2]); n++;
    es[n] = 2; ew[n] = 1; ed[n] = d; n++;
    es[n] = 3; ew[n] = 1; ed[n] = 32'(o) | 32'h8000; n++;
    for (int k = 0; k < nw; k++) begin es[n] = 3; ew[n] = 0; ed[n] = 0; n++; end
    es[n] = 1; ew[n] = 1; ed[n] = p0; n++;
    es[n] = 0; ew[n] = 1; ed[n] = c0; n++;
    es[n] = 3; ew[n] = 1; ed[n] = 32'(o) & ~32'h8000; n++;
    for (int k = 0; k < nr; k++) begin es[n] = 3; ew[n] = 0; ed[n] = 0; n++; end
    es[n] = 2; ew[n] = 0; ed[n] = 0; n++;
    for (int i = 0; i < n && i < lg_n; i++)
      if (bad < 0 && (lg_sel[i] != es[i] || lg_we[i] != ew[i] || (ew[i] && lg_wd[i] != ed[i])))
        bad = i;
    if (bad >= 0)
      chk(0, {req, " trace entry"}, {lg_sel[bad], 1'b0, lg_we[bad], lg_wd[bad][27:0]},
          {es[bad], 1'b0, ew[bad], ed[bad][27:0]});
    else
      chk(lg_n == n, {req, " trace length"}, 32'(lg_n), 32'(n));
  endtask

  task automatic t_reset();
    chk(!busy, "R2 reset busy", 32'(busy), 0);
    chk(!done, "R10 reset done", 32'(done), 0);
    chk(!reg_req, "R10 reset req", 32'(reg_req), 0);
  endtask

  task automatic t_misaligned();
    logic [1:0] st; int lat;
    setup(32'h0, 32'h0, 0, 0, 0);
    run_op(16'h0006, 32'h1111_2222, 0, st, lat);
    chk(st == 2'b01, "R1 misaligned status", 32'(st), 32'h1);
    chk(lat == 1, "R1 misaligned latency", 32'(lat), 32'h1);
    chk(lg_n == 0, "R1 no access", 32'(lg_n), 32'h0);
  endtask

  task automatic t_normal();
    logic [1:0] st; int lat; bit gap_ok;
    setup(32'h8000_00A5, 32'h7F, 3, 2, 0);
    run_op(16'h0010, 32'h1234_5678, 0, st, lat);
    chk(st == 2'b00, "R9 success status", 32'(st), 32'h0);
    check_trace("R3 R4 R5 R8", 16'h0010, 32'h1234_5678, 32'h8000_00A5, 32'h7F, 4, 3);
    chk(mem[4] == 32'h1234_5678, "R4 word stored past boundary", mem[4], 32'h1234_5678);
    chk(m_ctrl == 32'h8000_00A5, "R3 control restored", m_ctrl, 32'h8000_00A5);
    chk(m_prot == 32'h7F, "R4 protection restored", m_prot, 32'h7F);
    gap_ok = 1;
    for (int i = 4; i < 10 && i < lg_n; i++)
      if (i != 5 && lg_cyc[i] - lg_cyc[i-1] < DLY + 1) gap_ok = 0;
    chk(gap_ok, "R6 poll spacing", 32'(lg_cyc[7] - lg_cyc[6]), 32'(DLY + 1));
  endtask

  task automatic t_last_poll();
    logic [1:0] st; int lat;
    setup(32'h0, 32'h0, NPOLL - 1, 0, 0);
    run_op(16'h0020, 32'hCAFE_0001, 0, st, lat);
    chk(st == 2'b00, "R6 completion on last poll", 32'(st), 32'h0);
    check_trace("R6", 16'h0020, 32'hCAFE_0001, 32'h0, 32'h0, NPOLL, 1);
  endtask

  task automatic t_wr_timeout();
    logic [1:0] st; int lat;
    setup(32'h8000_0003, 32'h05, HANG, 1, 0);
    run_op(16'h0030, 32'h0BAD_F00D, 0, st, lat);
    chk(st == 2'b10, "R7 write timeout status", 32'(st), 32'h2);
    check_trace("R7", 16'h0030, 32'h0BAD_F00D, 32'h8000_0003, 32'h05, NPOLL, 2);
    chk(m_ctrl == 32'h8000_0003 && m_prot == 32'h05, "R7 restore after timeout", m_prot, 32'h05);
  endtask

  task automatic t_rd_timeout();
    logic [1:0] st; int lat;
    setup(32'h0, 32'h0, 0, HANG, 0);
    run_op(16'h0044, 32'h5555_AAAA, 0, st, lat);
    chk(st == 2'b10, "R8 readback timeout status", 32'(st), 32'h2);
    check_trace("R8", 16'h0044, 32'h5555_AAAA, 32'h0, 32'h0, 1, NPOLL);
  endtask

  task automatic t_mismatch();
    logic [1:0] st; int lat;
    setup(32'h0, 32'h0, 1, 1, 1);
    run_op(16'h0008, 32'h0F0F_0F0F, 0, st, lat);
    chk(st == 2'b11, "R9 mismatch status", 32'(st), 32'h3);
  endtask

  task automatic t_top_offset();
    logic [1:0] st; int lat;
    setup(32'h8000_0000, 32'h7F, 0, 0, 0);
    run_op(16'h01FC, 32'h8765_4321, 0, st, lat);
    chk(st == 2'b00, "R4 top dword status", 32'(st), 32'h0);
    check_trace("R4 top dword", 16'h01FC, 32'h8765_4321, 32'h8000_0000, 32'h7F, 1, 1);
  endtask

  task automatic t_busy_start();
    logic [1:0] st; int lat; bit extra; bit wrote40;
    setup(32'h0, 32'h0, 2, 2, 0);
    mem[16] = 32'h0000_4040;
    run_op(16'h0024, 32'h2424_2424, 6, st, lat);
    chk(st == 2'b00, "R2 first command status", 32'(st), 32'h0);
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done || busy) extra = 1;
    end
    chk(!extra, "R2 no second command", 32'(extra), 0);
    wrote40 = 0;
    for (int i = 0; i < lg_n; i++) if (lg_we[i] && lg_sel[i] == 2'd3 && lg_wd[i][8:0] == 9'h040) wrote40 = 1;
    chk(!wrote40 && mem[16] == 32'h0000_4040, "R2 ignored offset untouched", mem[16], 32'h0000_4040);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
    m_ctrl = '0; m_prot = '0; m_data = '0; m_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_misaligned();
    t_normal();
    t_last_poll();
    t_wr_timeout();
    t_rd_timeout();
    t_mismatch();
    t_top_offset();
    t_busy_start();
    summary();
    $finish;
  end
endmodule